// File: doc/BRIEF.md
# Timer Capture, Compare and PWM Channel

This block is one channel of a general-purpose timer. It watches a free-running counter that is shared with other channels and owned by logic outside the block. Register bits put the channel into one of three roles. It can time-stamp an edge on its pin by latching the counter value. It can drive its pin when the counter reaches a programmed value, and can also toggle the pin on every counter overflow, which together give an unbuffered PWM waveform. It can also release the pin to general-purpose use.

Software reaches the block through a small write port with two locations: a control word and the channel value word. Bit 0 of the control word is the mode bit. Bits 2:1 are the edge/level field, bit 3 is toggle-on-overflow and bit 4 is the channel flag. The value word holds the compare value in compare mode and the latched counter value in capture mode. The channel changes role only while the timer is halted. While the edge/level field is 00, the mode bit sets the level that the pin starts at when the channel takes the pin over.

Top module: `tmr_chan`

## Requirements
- R1: After reset the control word is all zero, the flag is 0, the channel value is 0, `pin_oe` is 0 and `pin_out` is 1.
- R2: While the edge/level field is 00, `pin_oe` is 0 and `pin_out` takes the inverse of the mode bit one clock after that bit changes: mode 1 gives a low output and mode 0 gives a high output.
- R3: With a non-zero edge/level field and mode 0, the channel is in capture mode and `pin_oe` is 0. Field value 01 captures on a rising edge, 10 on a falling edge and 11 on either edge. The captured counter value appears on `chan_value` three clocks after `pin_in` changes: two synchroniser flops, then the edge-detect stage.
- R4: In capture mode an edge that the field does not select leaves `chan_value` unchanged.
- R5: With a non-zero edge/level field and mode 1, the channel is in compare mode and `pin_oe` is 1. When `cnt_val` equals the channel value while the timer runs, the clock edge applies the action: 01 toggles the pin, 10 drives it low and 11 drives it high.
- R6: In compare mode with toggle-on-overflow set, `pin_out` toggles one clock after an `ovf_pulse` while the timer runs. If a compare match falls in the same cycle, only the match action is applied.
- R7: In capture mode, toggle-on-overflow has no effect on `pin_out`.
- R8: Writes to the mode bit and the edge/level field are ignored while `tmr_halt` is 0. Writes to toggle-on-overflow, the flag and the value word always take effect.
- R9: A capture or a compare match sets the sticky flag. An overflow does not set it. Writing the control word with bit 4 at 0 clears the flag, writing bit 4 at 1 leaves it as it is, and an event in the same cycle as a clear wins.
- R10: When the edge/level field goes from 00 to compare mode, `pin_out` begins at the level preset by the mode bit before the change.
- R11: While `tmr_halt` is 1, neither a compare match nor an overflow changes `pin_out` or sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | CNT_W | Shared free-running counter value |
| ovf_pulse | input | 1 | One-cycle counter overflow strobe |
| pin_in | input | 1 | Asynchronous level seen at the channel pin |
| tmr_halt | input | 1 | Timer stopped and held in reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control word, 1 selects the value word |
| wr_data | input | CNT_W | Write data |
| pin_out | output | 1 | Level driven onto the pin |
| pin_oe | output | 1 | Pin output enable, high in compare mode |
| chan_flag | output | 1 | Sticky capture/compare flag |
| chan_value | output | CNT_W | Compare value or last captured count |

## Verification
Assertions check several rules on every cycle. The mode and edge/level bits stay frozen while the timer runs. Every capture or match sets the flag. The value word holds when no capture or write reaches it. The pin is released whenever the channel is idle or capturing. The compare output stays put unless a match or an overflow toggle occurs, and no match fires while the timer is halted. Some behaviours depend on values in particular cycles, so only the bench scenarios show them: the exact compare action for each code, the three-clock capture latency, which edges each capture code ignores, overflow toggling and its priority against a same-cycle match, and the preset level taking effect when the channel claims the pin.

// File: rtl/tch_pkg.sv
// Package: shared types and field positions for the timer channel.
// Assumes a control word of at least five bits; the wider bits are unused.
package tch_pkg;
    typedef enum logic [1:0] {
        ELS_OFF  = 2'b00,
        ELS_A    = 2'b01,
        ELS_B    = 2'b10,
        ELS_BOTH = 2'b11
    } els_t;

    typedef struct packed {
        logic tov;
        els_t els;
        logic mode_a;
    } tch_cfg_t;

    localparam int MODE_BIT = 0;
    localparam int ELS_LO   = 1;
    localparam int ELS_HI   = 2;
    localparam int TOV_BIT  = 3;
    localparam int FLAG_BIT = 4;
endpackage

// File: rtl/tch_sync.sv
// Module tch_sync: brings the asynchronous pin into the clock domain
// through STAGES flops, then finds rising and falling edges.
// Assumes STAGES >= 2; the edge outputs last exactly one clock.
module tch_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // Stage 0 samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= pin_in;
    end

    // Later stages shift the level; the last one holds the previous value.
    for (genvar g = 1; g < CHAIN; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    // Edge detection compares the synchronised level with its delayed copy.
    always_comb begin
        rise = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
        fall = ~chain_q[CHAIN-2] & chain_q[CHAIN-1];
    end
endmodule

// File: rtl/tch_regs.sv
// Module tch_regs: control word, channel value word and sticky flag.
// Assumes cap_evt and cmp_evt never both come in one cycle (the modes exclude each other).
// The mode and edge/level bits change only while halt is high.
module tch_regs
    import tch_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             halt,
    input  logic             cap_evt,
    input  logic             cmp_evt,
    input  logic [CNT_W-1:0] cnt_val,
    output tch_cfg_t         cfg,
    output logic [CNT_W-1:0] value,
    output logic             flag
);
    logic ctl_wr;
    logic val_wr;

    // Decode which word a write strobe targets.
    always_comb begin
        ctl_wr = wr_en && !wr_sel;
        val_wr = wr_en && wr_sel;
    end

    // Control word: tov always writable, role bits only when halted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (ctl_wr) begin
            cfg.tov <= wr_data[TOV_BIT];
            if (halt) begin
                cfg.mode_a <= wr_data[MODE_BIT];
                cfg.els    <= els_t'(wr_data[ELS_HI:ELS_LO]);
            end
        end
    end

    // Value word: a capture takes priority over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)      value <= '0;
        else if (cap_evt) value <= cnt_val;
        else if (val_wr)  value <= wr_data;
    end

    // Sticky flag: events set it, a written zero clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                           flag <= 1'b0;
        else if (cap_evt || cmp_evt)          flag <= 1'b1;
        else if (ctl_wr && !wr_data[FLAG_BIT]) flag <= 1'b0;
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !halt |=> $stable({cfg.mode_a, cfg.els})) else $error("cfg changed while running"); // R8
    AST_FLAG_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt || cmp_evt) |=> flag) else $error("flag not set"); // R9
    AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_evt && !val_wr) |=> $stable(value)) else $error("value moved"); // R4
endmodule

// File: rtl/tch_outdrv.sv
// Module tch_outdrv: pin output register for compare, overflow toggle and preset.
// Assumes ovf_pulse lasts one clock; while idle (edge/level 00) the register
// follows the inverse of the mode bit so the pin starts at that level.
module tch_outdrv
    import tch_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tch_cfg_t         cfg,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] value,
    input  logic             ovf_pulse,
    input  logic             halt,
    output logic             pin_q,
    output logic             pin_oe,
    output logic             cmp_evt
);
    logic cmp_mode;
    logic ovf_tog;

    // Mode decode, match detect and overflow-toggle qualification.
    always_comb begin
        cmp_mode = (cfg.els != ELS_OFF) && cfg.mode_a;
        cmp_evt  = cmp_mode && !halt && (cnt_val == value);
        ovf_tog  = cmp_mode && !halt && cfg.tov && ovf_pulse;
        pin_oe   = cmp_mode;
    end

    // Pin register: preset while idle, match action first, then overflow toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b1;
        end else if (cfg.els == ELS_OFF) begin
            pin_q <= ~cfg.mode_a;
        end else if (cmp_evt) begin
            case (cfg.els)
                ELS_A:    pin_q <= ~pin_q;
                ELS_B:    pin_q <= 1'b0;
                ELS_BOTH: pin_q <= 1'b1;
                default:  pin_q <= pin_q;
            endcase
        end else if (ovf_tog) begin
            pin_q <= ~pin_q;
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.els == ELS_OFF) |-> !pin_oe) else $error("pin driven while idle"); // R2
    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_mode && !cmp_evt && !ovf_tog) |=> $stable(pin_q)) else $error("pin moved"); // R5
    AST_HALT_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !cmp_evt) else $error("match while halted"); // R11
endmodule

// File: rtl/tmr_chan.sv
// Module tmr_chan: one capture/compare/PWM channel attached to a shared counter.
// Assumes the counter and its overflow strobe come from outside and that
// software halts the timer before it changes the channel role.
module tmr_chan
    import tch_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             ovf_pulse,
    input  logic             pin_in,
    input  logic             tmr_halt,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             chan_flag,
    output logic [CNT_W-1:0] chan_value
);
    tch_cfg_t cfg;
    logic     rise, fall;
    logic     cap_evt, cmp_evt;
    logic     cap_mode;

    tch_sync #(.STAGES(SYNC_STGS)) i_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .rise(rise), .fall(fall)
    );

    // Capture qualification: the edge/level code picks the sensitive edge.
    always_comb begin
        cap_mode = (cfg.els != ELS_OFF) && !cfg.mode_a;
        case (cfg.els)
            ELS_A:    cap_evt = cap_mode && rise;
            ELS_B:    cap_evt = cap_mode && fall;
            ELS_BOTH: cap_evt = cap_mode && (rise || fall);
            default:  cap_evt = 1'b0;
        endcase
    end

    tch_regs #(.CNT_W(CNT_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .halt(tmr_halt), .cap_evt(cap_evt),
        .cmp_evt(cmp_evt), .cnt_val(cnt_val), .cfg(cfg),
        .value(chan_value), .flag(chan_flag)
    );

    tch_outdrv #(.CNT_W(CNT_W)) i_out (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .cnt_val(cnt_val),
        .value(chan_value), .ovf_pulse(ovf_pulse), .halt(tmr_halt),
        .pin_q(pin_out), .pin_oe(pin_oe), .cmp_evt(cmp_evt)
    );

    AST_CAPTURE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |-> !pin_oe) else $error("pin driven while capturing"); // R3
endmodule

// File: tb/test_tmr_chan.sv
`timescale 1ns/1ps
module test_tmr_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        ovf_pulse = 1'b0;
    logic        pin_in = 1'b0;
    logic        tmr_halt = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        pin_out, pin_oe, chan_flag;
    logic [15:0] chan_value;
    int          total = 0;
    int          bad = 0;

    // Compare-action vectors: [3:2] action code, [1] preset mode bit, [0] expected pin.
    localparam logic [3:0] VEC [6] = '{
        4'b01_0_0, 4'b01_1_1, 4'b10_0_0, 4'b10_1_0, 4'b11_1_1, 4'b11_0_1
    };

    always #4 clk = ~clk;

    tmr_chan i_tmr_chan (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .ovf_pulse(ovf_pulse),
        .pin_in(pin_in), .tmr_halt(tmr_halt), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pin_out(pin_out), .pin_oe(pin_oe),
        .chan_flag(chan_flag), .chan_value(chan_value)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ctl(input logic f, input logic tov,
                                       input logic [1:0] els, input logic m);
        return {11'b0, f, tov, els, m};
    endfunction

    task automatic wr(input logic sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        #800000;
        bad++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk); tick(); tick();
        rst_n = 1'b1;
        tick();
        chk("R1 oe", pin_oe, 0);
        chk("R1 pin", pin_out, 1);
        chk("R1 flag", chan_flag, 0);
        chk("R1 value", chan_value, 0);

        wr(0, ctl(1, 0, 2'b00, 1)); tick();
        chk("R2 preset low", pin_out, 0);
        chk("R2 oe", pin_oe, 0);
        wr(0, ctl(1, 0, 2'b00, 0)); tick();
        chk("R2 preset high", pin_out, 1);

        for (int i = 0; i < 6; i++) begin
            tmr_halt = 1'b1; cnt_val = 16'h0000;
            wr(0, ctl(1, 0, 2'b00, VEC[i][1])); tick();
            wr(1, 16'h0040);
            wr(0, ctl(1, 0, VEC[i][3:2], 1));
            chk("R10 start level", pin_out, {15'b0, ~VEC[i][1]});
            tmr_halt = 1'b0; cnt_val = 16'h0040;
            tick();
            chk("R5 action", pin_out, {15'b0, VEC[i][0]});
            cnt_val = 16'h0000;
        end

        tmr_halt = 1'b1;
        wr(0, ctl(0, 0, 2'b00, 0)); tick();
        tmr_halt = 1'b0;
        wr(0, ctl(0, 0, 2'b11, 1));
        chk("R8 role write ignored", pin_oe, 0);
        tmr_halt = 1'b1;
        wr(0, ctl(0, 0, 2'b11, 1));
        chk("R8 role write halted", pin_oe, 1);
        chk("R10 preset kept", pin_out, 1);

        wr(1, 16'h0005);
        wr(0, ctl(0, 0, 2'b01, 1));
        cnt_val = 16'h0005; tick(); tick();
        chk("R11 pin halted", pin_out, 1);
        chk("R11 flag halted", chan_flag, 0);
        tmr_halt = 1'b0; tick();
        chk("R5 toggle", pin_out, 0);
        chk("R9 flag set", chan_flag, 1);
        cnt_val = 16'h0006;
        wr(0, ctl(1, 0, 2'b01, 1));
        chk("R9 write one keeps", chan_flag, 1);
        wr(0, ctl(0, 0, 2'b01, 1));
        chk("R9 write zero clears", chan_flag, 0);

        wr(0, ctl(0, 1, 2'b01, 1));
        ovf_pulse = 1'b1; tick(); ovf_pulse = 1'b0;
        chk("R6 overflow toggle", pin_out, 1);
        chk("R9 overflow no flag", chan_flag, 0);
        tmr_halt = 1'b1;
        wr(0, ctl(0, 1, 2'b10, 1));
        ovf_pulse = 1'b1; tick(); ovf_pulse = 1'b0;
        chk("R11 overflow halted", pin_out, 1);
        tmr_halt = 1'b0;
        ovf_pulse = 1'b1; tick();
        chk("R6 overflow toggle2", pin_out, 0);
        cnt_val = 16'h0005; tick(); ovf_pulse = 1'b0;
        chk("R6 match wins", pin_out, 0);
        cnt_val = 16'h0006;

        tmr_halt = 1'b1;
        wr(0, ctl(0, 1, 2'b01, 0));
        chk("R3 oe capture", pin_oe, 0);
        tmr_halt = 1'b0;
        ovf_pulse = 1'b1; tick(); ovf_pulse = 1'b0;
        chk("R7 tov ignored", pin_out, 0);

        cnt_val = 16'h1234; pin_in = 1'b1;
        tick(); tick();
        chk("R3 latency", chan_value, 16'h0005);
        tick();
        chk("R3 rising capture", chan_value, 16'h1234);
        chk("R9 capture flag", chan_flag, 1);
        cnt_val = 16'h2222; pin_in = 1'b0;
        tick(); tick(); tick(); tick();
        chk("R4 falling ignored", chan_value, 16'h1234);

        tmr_halt = 1'b1;
        wr(0, ctl(0, 0, 2'b11, 0));
        tmr_halt = 1'b0;
        cnt_val = 16'h3333; pin_in = 1'b1;
        tick(); tick(); tick();
        chk("R3 either rising", chan_value, 16'h3333);
        cnt_val = 16'h4444; pin_in = 1'b0;
        tick(); tick(); tick();
        chk("R3 either falling", chan_value, 16'h4444);

        tmr_halt = 1'b1;
        wr(0, ctl(0, 0, 2'b10, 0));
        tmr_halt = 1'b0;
        cnt_val = 16'h5555; pin_in = 1'b1;
        tick(); tick(); tick(); tick();
        chk("R4 rising ignored", chan_value, 16'h4444);
        cnt_val = 16'h6666; pin_in = 1'b0;
        tick(); tick(); tick();
        chk("R3 falling capture", chan_value, 16'h6666);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule